// File: doc/BRIEF.md
# Time-Slotted Serial Audio Frame Transmitter

This block is the controller end of a time-division serial audio link. It runs on the bit clock and sends a fixed-length frame over and over: a 16-bit tag slot first, then twelve 20-bit data slots, 256 bit periods in all. It drives a frame marker, `sync_o`, and one serial data line, `sdata_o`. At 48 kHz frames the bit clock runs at about 12.288 MHz. The host supplies one parallel word per data slot and one valid flag per data slot. The block copies both into shadow registers at each frame boundary. It builds the tag slot from the copied flags and sends zeros in place of any slot whose flag is clear.

The marker rises on a rising bit-clock edge and stays high for the 16 periods of the tag slot. Frame data trails the marker by one period, so the far side sees the marker on a falling edge and takes the first tag bit on the next falling edge. A power-down input holds both outputs low. When power-down is released, the block starts again on a clean frame boundary.

Top module: `audio_frame_tx`

## Requirements
- R1: `sync_o` rises once every 256 clock periods while the block is running. That is a 16-bit tag slot plus twelve 20-bit data slots.
- R2: Once it rises, `sync_o` stays high for exactly 16 periods and then stays low for the other 240.
- R3: Frame bit k (k = 0..255) appears on `sdata_o` k+1 periods after `sync_o` rises. The last bit of a frame therefore shares a period with the rise of the next frame's `sync_o`.
- R4: Frame bit 0, the whole-frame valid flag, is 1 exactly when at least one of the captured slot valid flags is set.
- R5: Frame bits 1 to 12 carry the captured valid flags of data slots 1 to 12, in slot order. Slot s uses `slot_vld_i[s-1]`.
- R6: Frame bits 13, 14 and 15, the last three bits of the tag slot, are always 0.
- R7: A valid data slot s sends `slot_data_i[(s-1)*20 +: 20]` most significant bit first. It occupies frame bits 16+20*(s-1) to 35+20*(s-1).
- R8: A data slot whose captured valid flag is 0 sends all 20 bits as 0, whatever its data word holds.
- R9: Data and valid flags are sampled only on the clock edge where `sync_o` rises. A change at any other time has no effect on the frame being sent.
- R10: One edge after `pwr_down_i` is sampled high, `sync_o` and `sdata_o` go low and stay low. The first edge after release raises `sync_o` while `sdata_o` sends 0, and a fresh frame follows from the inputs sampled on that edge.
- R11: During reset both outputs are 0. The first clock edge after reset is released raises `sync_o` and samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Holds the link quiet and idle while high |
| slot_data_i | input | 240 | Data words, slot s at bits (s-1)*20 +: 20 |
| slot_vld_i | input | 12 | Valid flag per data slot, slot s at bit s-1 |
| sync_o | output | 1 | Frame marker, high during the tag slot |
| sdata_o | output | 1 | Serial frame data, one bit per period |

## Verification
The bound checker follows the frame from the ports on every cycle. It checks the 256-period spacing of marker rises and the 16-period marker width. It checks that the first tag bit equals the OR of the flags present at the capture edge, that the three pad bits of the tag stay zero, and that both lines fall silent one edge after power-down. The bench scenarios are needed for everything else. They check each slot's tag position and MSB-first data order, zero-stuffing of invalid slots, and that a mid-frame change of the inputs leaves the frame being sent untouched. They also check the clean restart after power-down. For these, the bench compares every serial bit against a frame it builds itself from the words it drove.

// File: rtl/aft_pkg.sv
`timescale 1ns/1ps
package aft_pkg;
   // defaults for the standard link layout
   parameter int AFT_SLOTS  = 12;
   parameter int AFT_SLOT_W = 20;
   parameter int AFT_TAG_W  = 16;

   function automatic int aft_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int aft_clog2p(input int n);
      int r;
      r = 1;
      while ((1 << r) < n) r++;
      return r;
   endfunction
endpackage

// File: rtl/aft_frame_timer.sv
`timescale 1ns/1ps
module aft_frame_timer #(
   parameter int SLOTS  = aft_pkg::AFT_SLOTS,
   parameter int SLOT_W = aft_pkg::AFT_SLOT_W,
   parameter int TAG_W  = aft_pkg::AFT_TAG_W,
   localparam int SIW   = aft_pkg::aft_clog2p(SLOTS + 1),
   localparam int BIW   = aft_pkg::aft_clog2p(aft_pkg::aft_max(TAG_W, SLOT_W))
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwr_down_i,
   output logic [SIW-1:0] slot_o,
   output logic [BIW-1:0] bit_o,
   output logic           wrap_o,
   output logic           sync_nx_o
);
   localparam logic [SIW-1:0] LAST_SLOT = SIW'(SLOTS);
   localparam logic [BIW-1:0] TAG_TOP   = BIW'(TAG_W - 1);
   localparam logic [BIW-1:0] SLOT_TOP  = BIW'(SLOT_W - 1);

   logic [SIW-1:0] slot_q;
   logic [BIW-1:0] bit_q;
   logic           wrap;

   // idle position is the last bit of the last slot, so the next edge opens a frame
   assign wrap = (slot_q == LAST_SLOT) && (bit_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= LAST_SLOT;
         bit_q  <= '0;
      end else if (pwr_down_i) begin
         slot_q <= LAST_SLOT;
         bit_q  <= '0;
      end else if (bit_q == '0) begin
         if (wrap) begin
            slot_q <= '0;
            bit_q  <= TAG_TOP;
         end else begin
            slot_q <= slot_q + 1'b1;
            bit_q  <= SLOT_TOP;
         end
      end else begin
         bit_q <= bit_q - 1'b1;
      end
   end

   assign slot_o    = slot_q;
   assign bit_o     = bit_q;
   assign wrap_o    = wrap;
   // the position entered at the next edge lies in the tag slot
   assign sync_nx_o = wrap || ((slot_q == '0) && (bit_q != '0));
endmodule

// File: rtl/aft_tag_builder.sv
`timescale 1ns/1ps
module aft_tag_builder #(
   parameter int SLOTS = aft_pkg::AFT_SLOTS,
   parameter int TAG_W = aft_pkg::AFT_TAG_W,
   localparam int PAD  = TAG_W - 1 - SLOTS
) (
   input  logic [SLOTS-1:0] vld_i,
   output logic [TAG_W-1:0] tag_o
);
   // top bit: whole-frame valid
   assign tag_o[TAG_W-1] = |vld_i;

   for (genvar s = 1; s <= SLOTS; s++) begin : g_flag
      assign tag_o[TAG_W-1-s] = vld_i[s-1];
   end

   for (genvar p = 0; p < PAD; p++) begin : g_pad
      assign tag_o[p] = 1'b0;
   end
endmodule

// File: rtl/aft_slot_shadow.sv
`timescale 1ns/1ps
module aft_slot_shadow #(
   parameter int SLOTS         = aft_pkg::AFT_SLOTS,
   parameter int SLOT_W        = aft_pkg::AFT_SLOT_W,
   parameter bit STUFF_AT_LOAD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic                    clear_i,
   input  logic [SLOTS*SLOT_W-1:0] data_i,
   input  logic [SLOTS-1:0]        vld_i,
   output logic [SLOTS*SLOT_W-1:0] data_o,
   output logic [SLOTS-1:0]        vld_o
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [SLOT_W-1:0] word_q;
      logic              vld_q;
      logic [SLOT_W-1:0] word_in;

      if (STUFF_AT_LOAD) begin : g_mask_in
         assign word_in = data_i[s*SLOT_W +: SLOT_W] & {SLOT_W{vld_i[s]}};
      end else begin : g_raw_in
         assign word_in = data_i[s*SLOT_W +: SLOT_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
         end else if (clear_i) begin
            word_q <= '0;
            vld_q  <= 1'b0;
         end else if (load_i) begin
            word_q <= word_in;
            vld_q  <= vld_i[s];
         end
      end

      assign data_o[s*SLOT_W +: SLOT_W] = word_q;
      assign vld_o[s]                   = vld_q;
   end
endmodule

// File: rtl/aft_bit_pick.sv
`timescale 1ns/1ps
module aft_bit_pick #(
   parameter int SLOTS         = aft_pkg::AFT_SLOTS,
   parameter int SLOT_W        = aft_pkg::AFT_SLOT_W,
   parameter int TAG_W         = aft_pkg::AFT_TAG_W,
   parameter bit STUFF_AT_LOAD = 1'b1,
   localparam int SIW          = aft_pkg::aft_clog2p(SLOTS + 1),
   localparam int WW           = aft_pkg::aft_max(TAG_W, SLOT_W),
   localparam int BIW          = aft_pkg::aft_clog2p(WW)
) (
   input  logic [SIW-1:0]          slot_i,
   input  logic [BIW-1:0]          bit_i,
   input  logic [TAG_W-1:0]        tag_i,
   input  logic [SLOTS*SLOT_W-1:0] data_i,
   input  logic [SLOTS-1:0]        vld_i,
   output logic                    bit_o
);
   logic [WW-1:0] words [0:SLOTS];

   always_comb begin
      for (int s = 0; s <= SLOTS; s++) words[s] = '0;
      words[0][TAG_W-1:0] = tag_i;
      for (int s = 1; s <= SLOTS; s++) begin
         if (STUFF_AT_LOAD)
            words[s][SLOT_W-1:0] = data_i[(s-1)*SLOT_W +: SLOT_W];
         else
            words[s][SLOT_W-1:0] = data_i[(s-1)*SLOT_W +: SLOT_W] & {SLOT_W{vld_i[s-1]}};
      end
   end

   assign bit_o = words[slot_i][bit_i];
endmodule

// File: rtl/audio_frame_tx.sv
`timescale 1ns/1ps
module audio_frame_tx #(
   parameter int SLOTS         = aft_pkg::AFT_SLOTS,
   parameter int SLOT_W        = aft_pkg::AFT_SLOT_W,
   parameter int TAG_W         = aft_pkg::AFT_TAG_W,
   parameter bit STUFF_AT_LOAD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pwr_down_i,
   input  logic [SLOTS*SLOT_W-1:0] slot_data_i,
   input  logic [SLOTS-1:0]        slot_vld_i,
   output logic                    sync_o,
   output logic                    sdata_o
);
   localparam int SIW = aft_pkg::aft_clog2p(SLOTS + 1);
   localparam int WW  = aft_pkg::aft_max(TAG_W, SLOT_W);
   localparam int BIW = aft_pkg::aft_clog2p(WW);

   // elaboration-time parameter checks
   if (SLOTS < 1 || SLOTS > 255) begin : g_bad_slots
      $error("audio_frame_tx: SLOTS out of range");
   end
   if (SLOT_W < 1) begin : g_bad_width
      $error("audio_frame_tx: SLOT_W must be positive");
   end
   if (TAG_W < SLOTS + 1) begin : g_bad_tag
      $error("audio_frame_tx: tag slot too narrow for its flags");
   end

   logic [SIW-1:0]          slot_idx;
   logic [BIW-1:0]          bit_idx;
   logic                    wrap;
   logic                    sync_nx;
   logic [SLOTS*SLOT_W-1:0] sh_data;
   logic [SLOTS-1:0]        sh_vld;
   logic [TAG_W-1:0]        tag;
   logic                    cur_bit;

   aft_frame_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_down_i(pwr_down_i),
      .slot_o    (slot_idx),
      .bit_o     (bit_idx),
      .wrap_o    (wrap),
      .sync_nx_o (sync_nx)
   );

   aft_slot_shadow #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .STUFF_AT_LOAD(STUFF_AT_LOAD)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wrap && !pwr_down_i),
      .clear_i(pwr_down_i),
      .data_i (slot_data_i),
      .vld_i  (slot_vld_i),
      .data_o (sh_data),
      .vld_o  (sh_vld)
   );

   aft_tag_builder #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_tag (
      .vld_i(sh_vld),
      .tag_o(tag)
   );

   aft_bit_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W),
                  .STUFF_AT_LOAD(STUFF_AT_LOAD)) u_pick (
      .slot_i(slot_idx),
      .bit_i (bit_idx),
      .tag_i (tag),
      .data_i(sh_data),
      .vld_i (sh_vld),
      .bit_o (cur_bit)
   );

   // data lags the marker by one period: the bit of the current position goes out now
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_o  <= 1'b0;
         sdata_o <= 1'b0;
      end else if (pwr_down_i) begin
         sync_o  <= 1'b0;
         sdata_o <= 1'b0;
      end else begin
         sync_o  <= sync_nx;
         sdata_o <= cur_bit;
      end
   end
endmodule

// File: rtl/aft_tx_chk.sv
`timescale 1ns/1ps
module aft_tx_chk #(
   parameter int SLOTS  = aft_pkg::AFT_SLOTS,
   parameter int SLOT_W = aft_pkg::AFT_SLOT_W,
   parameter int TAG_W  = aft_pkg::AFT_TAG_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_down_i,
   input logic [SLOTS-1:0] slot_vld_i,
   input logic             sync_o,
   input logic             sdata_o
);
   localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W;
   localparam int CW        = aft_pkg::aft_clog2p(FRAME_LEN + 2);

   logic          sync_d;
   logic          seen;
   logic [CW-1:0] since;
   logic          rise;

   assign rise = sync_o && !sync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_d <= 1'b0;
         seen   <= 1'b0;
         since  <= '0;
      end else begin
         sync_d <= sync_o;
         if (pwr_down_i) begin
            seen  <= 1'b0;
            since <= '0;
         end else if (rise) begin
            seen  <= 1'b1;
            since <= CW'(1);
         end else if (since != '1) begin
            since <= since + 1'b1;
         end
      end
   end

   // R1
   period_len_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_down_i)
      (rise && seen) |-> (since == CW'(FRAME_LEN)));

   // R2
   sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_down_i)
      (seen && !rise) |-> (sync_o == (since < CW'(TAG_W))));

   // R4
   frame_valid_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_down_i)
      $rose(sync_o) |=> (sdata_o == (|$past(slot_vld_i, 2))));

   // R6
   tag_pad_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_down_i)
      (seen && !rise && since >= CW'(SLOTS + 2) && since <= CW'(TAG_W)) |-> !sdata_o);

   // R10
   pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down_i |=> (!sync_o && !sdata_o));
endmodule

bind audio_frame_tx aft_tx_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_down_i(pwr_down_i),
   .slot_vld_i(slot_vld_i),
   .sync_o    (sync_o),
   .sdata_o   (sdata_o)
);

// File: tb/audio_frame_tx_bench.sv
`timescale 1ns/1ps
module audio_frame_tx_bench;
   localparam int SLOTS = 12;
   localparam int SW    = 20;
   localparam int TW    = 16;
   localparam int FL    = TW + SLOTS * SW;

   typedef logic [FL-1:0] frame_t;
   typedef struct {
      frame_t             f;
      logic [SLOTS-1:0]   v;
   } exp_t;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  pd = 1'b0;
   logic [SLOTS*SW-1:0]   data = '0;
   logic [SLOTS-1:0]      vld = '0;
   logic                  sync_w;
   logic                  sd_w;

   exp_t  q[$];
   event  frm_ev;
   int    total = 0;
   int    bad = 0;
   bit    mon_on = 1'b1;
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   audio_frame_tx u_audio_frame_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_down_i (pd),
      .slot_data_i(data),
      .slot_vld_i (vld),
      .sync_o     (sync_w),
      .sdata_o    (sd_w)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic frame_t build(input logic [SLOTS*SW-1:0] d, input logic [SLOTS-1:0] v);
      frame_t e;
      e = '0;
      e[0] = |v;
      for (int s = 1; s <= SLOTS; s++) e[s] = v[s-1];
      for (int k = TW; k < FL; k++) begin
         int s;
         int b;
         s = (k - TW) / SW;
         b = SW - 1 - ((k - TW) % SW);
         e[k] = v[s] ? d[s*SW + b] : 1'b0;
      end
      return e;
   endfunction

   // monitor: pops one expected frame per marker rise and compares every bit
   initial begin
      exp_t  cur;
      bit    active;
      bit    prev;
      int    pos;
      active = 1'b0;
      prev   = 1'b0;
      pos    = 0;
      forever begin
         @(negedge clk);
         if (!rst_n || !mon_on) begin
            active = 1'b0;
            prev   = sync_w;
            pos    = 0;
         end else if (sync_w && !prev) begin
            if (active) begin
               check(pos == FL - 1, "R1", "frame period", pos + 1, FL);
               check(sd_w == cur.f[FL-1], "R3", "last bit at next rise", sd_w, cur.f[FL-1]);
            end
            pos  = 0;
            prev = 1'b1;
            if (q.size() > 0) begin
               cur    = q.pop_front();
               active = 1'b1;
            end else begin
               active = 1'b0;
            end
            ->frm_ev;
         end else begin
            prev = sync_w;
            pos++;
            if (active && pos < FL) begin
               string req;
               int k;
               k = pos - 1;
               check(sync_w == (pos < TW), "R2", $sformatf("marker at pos %0d", pos),
                     sync_w, (pos < TW));
               if (k == 0) req = "R4";
               else if (k <= SLOTS) req = "R5";
               else if (k < TW) req = "R6";
               else if (cur.v[(k - TW) / SW]) req = "R7";
               else req = "R8";
               check(sd_w == cur.f[k], req, $sformatf("frame bit %0d", k), sd_w, cur.f[k]);
            end
         end
      end
   end

   // driver: after a rise, drive the words that the next rise captures
   task automatic send(input logic [SLOTS*SW-1:0] d, input logic [SLOTS-1:0] v, input bit glitch);
      exp_t e;
      @(frm_ev);
      #1;
      if (glitch) begin
         // R9: mid-frame changes must not reach the frame in flight
         data = ~data;
         vld  = ~vld;
         repeat (150) @(negedge clk);
      end
      data = d;
      vld  = v;
      e.f  = build(d, v);
      e.v  = v;
      q.push_back(e);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [SLOTS*SW-1:0] pat;
      exp_t e;
      for (int s = 0; s < SLOTS; s++) pat[s*SW +: SW] = 20'hA5C3B ^ SW'(s * 20'h1111);

      repeat (4) @(negedge clk);
      check(sync_w == 1'b0 && sd_w == 1'b0, "R11", "outputs during reset",
            {sync_w, sd_w}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sync_w == 1'b1, "R11", "marker after reset release", sync_w, 1);

      send(pat, '1, 1'b0);
      send(~pat, '0, 1'b0);
      send(pat, 12'b1010_1010_1010, 1'b0);
      send('1, 12'b1000_0000_0000, 1'b0);
      send(pat ^ {SLOTS{20'h0F0F0}}, 12'b0000_0000_0001, 1'b0);
      send({SLOTS{20'h80001}}, 12'b0110_0011_1100, 1'b1);
      send(pat, 12'b0101_0101_0101, 1'b1);

      // power-down in the middle of a frame
      @(frm_ev);
      #1;
      repeat (60) @(negedge clk);
      pd = 1'b1;
      mon_on = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         data = ~data;
         check(sync_w == 1'b0 && sd_w == 1'b0, "R10", "quiet while powered down",
               {sync_w, sd_w}, 0);
      end
      q.delete();
      data = pat;
      vld  = 12'b1100_0011_0110;
      e.f  = build(data, vld);
      e.v  = vld;
      q.push_back(e);
      pd = 1'b0;
      mon_on = 1'b1;
      @(negedge clk);
      check(sync_w == 1'b1 && sd_w == 1'b0, "R10", "restart marker and zero bit",
            {sync_w, sd_w}, 2'b10);

      send(~pat, '1, 1'b0);
      send(pat, 12'b0000_0000_0000, 1'b0);
      @(frm_ev);
      @(frm_ev);
      @(negedge clk);
      finish_run();
   end
endmodule